// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block puts a multi-output clock generator into a deep low-power state and brings it back out in a safe order. A power-down request arrives on an asynchronous active-low pin. It is resynchronized into the falling-edge domain of the internal CPU-rate clock. Every gated output is then parked low, each on a low phase of its own source clock. Only when all of them sit low are the crystal and VCO enables withdrawn. When the request is released, the crystal is restarted first. The VCO follows after a programmable crystal warm-up count, and the outputs reopen once a second, programmable lock count has expired. The two counts are checked at elaboration against a 3 ms power-up budget at the configured core clock rate.

Each output channel is given a class by parameter: CPU-rate, PCI-rate or free-running. In normal operation the synchronized CPU-stop and PCI-stop inputs park their own classes, and free-running channels keep running. While a power-down is in progress or held, neither stop input has any effect. The source clocks are supplied to the block, and it returns both the gate enables and the gated clocks themselves.

Top module: `clk_pwrdn_seq`

## Requirements
- R1: The power-down, CPU-stop and PCI-stop pins each pass through two falling-edge flops. A level driven before falling edge 1 can change a gate no earlier than falling edge 3.
- R2: Once a power-down request is visible, each gate goes low at the first falling edge at which its own source clock is low. It stays low for as long as the block is powered down.
- R3: `xtal_en` and `vco_en` fall only when every bit of `gate_en` is already 0.
- R4: A bit of `gate_en` changes only at a falling edge at which its source clock is low, so no gated output is ever cut short or started with a runt high pulse.
- R5: After the synchronized release, `xtal_en` rises at the next falling edge. This is falling edge 3 counted from the release. `vco_en` rises exactly `XTAL_SETTLE` falling edges later. `vco_en` is never 1 while `xtal_en` is 0.
- R6: Gates stay closed until `PLL_SETTLE` falling edges after `vco_en` rose, and no gate is ever open while `vco_en` is 0.
- R7: While power-down is active, changes on `cpu_stop_n` and `pci_stop_n` leave `gate_en`, `xtal_en` and `vco_en` unchanged.
- R8: When powered up, a low `cpu_stop_n` parks only the CPU-class channels. A low `pci_stop_n` parks only the PCI-class channels. Free-running channels ignore both. Each class is a 2-bit field per channel in `CH_CLASS`: 0 means free-running, 1 means CPU and 2 means PCI.
- R9: A new power-down request seen during crystal warm-up or PLL lock aborts the restart. Both oscillator enables return to 0 at the next falling edge.
- R10: During reset `gate_en` is 0, `clk_out` is 0, and `xtal_en` and `vco_en` are 1.
- R11: `clk_out[i]` equals `src_clk[i]` AND `gate_en[i]` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Internal CPU-rate clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous stop for CPU-class channels, active low |
| pci_stop_n | input | 1 | Asynchronous stop for PCI-class channels, active low |
| src_clk | input | NUM_CH | Ungated source clock of each channel |
| gate_en | output | NUM_CH | Per-channel gate enable |
| clk_out | output | NUM_CH | Gated clock per channel |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The bench builds the block with four channels: one CPU-class, two PCI-class and one free-running. It shortens the settle counts to 4 and 6 cycles and lowers the core rate so that the budget check still holds. The short counts make whole power-down and restart cycles fit in a few dozen clocks. They also let the bench hit the abort window in the middle of PLL lock. The four source clocks are set to half-periods of 1, 2, 3 and 5 core cycles. This makes the slowest channel wait visibly for its own low phase, so gates close on different edges.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_STOP_OUT,
      ST_OSC_OFF,
      ST_OSC_START,
      ST_SETTLE
   } pd_state_e;

   localparam logic [1:0] CLS_FREE = 2'd0;
   localparam logic [1:0] CLS_CPU  = 2'd1;
   localparam logic [1:0] CLS_PCI  = 2'd2;

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
   parameter int               WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk_core,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage1;

   // two-flop resynchronizer in the falling-edge domain
   always_ff @(negedge clk_core or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= RST_VAL;
         q      <= RST_VAL;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end

endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
   import pdseq_pkg::*;
#(
   parameter int XTAL_SETTLE = 4,
   parameter int PLL_SETTLE  = 6
) (
   input  logic clk_core,
   input  logic rst_n,
   input  logic pd_req,
   input  logic all_off,
   output logic run_ok,
   output logic xtal_en,
   output logic vco_en
);

   localparam int MAX_SETTLE = (XTAL_SETTLE > PLL_SETTLE) ? XTAL_SETTLE : PLL_SETTLE;
   localparam int CW         = $clog2(MAX_SETTLE + 1);
   localparam logic [CW-1:0] XS_LOAD = CW'(XTAL_SETTLE - 1);
   localparam logic [CW-1:0] PS_LOAD = CW'(PLL_SETTLE - 1);

   pd_state_e     state, state_nxt;
   logic [CW-1:0] cnt, cnt_nxt;

   always_comb begin
      state_nxt = state;
      cnt_nxt   = cnt;
      case (state)
         ST_RUN:      if (pd_req) state_nxt = ST_STOP_OUT;
         ST_STOP_OUT: if (all_off) state_nxt = ST_OSC_OFF;
         ST_OSC_OFF: begin
            if (!pd_req) begin
               state_nxt = ST_OSC_START;
               cnt_nxt   = XS_LOAD;
            end
         end
         ST_OSC_START: begin
            if (pd_req) begin
               state_nxt = ST_OSC_OFF;
            end else if (cnt == '0) begin
               state_nxt = ST_SETTLE;
               cnt_nxt   = PS_LOAD;
            end else begin
               cnt_nxt = cnt - 1'b1;
            end
         end
         ST_SETTLE: begin
            if (pd_req)          state_nxt = ST_OSC_OFF;
            else if (cnt == '0)  state_nxt = ST_RUN;
            else                 cnt_nxt   = cnt - 1'b1;
         end
         default: state_nxt = ST_OSC_OFF;
      endcase
   end

   always_ff @(negedge clk_core or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RUN;
         cnt   <= '0;
      end else begin
         state <= state_nxt;
         cnt   <= cnt_nxt;
      end
   end

   assign run_ok  = (state == ST_RUN) && !pd_req;
   assign xtal_en = (state != ST_OSC_OFF);
   assign vco_en  = (state != ST_OSC_OFF) && (state != ST_OSC_START);

endmodule

// File: rtl/pdseq_gate_cell.sv
module pdseq_gate_cell (
   input  logic clk_core,
   input  logic rst_n,
   input  logic src_clk,
   input  logic want,
   output logic gate_en,
   output logic clk_out
);

   // the enable may only move while the source is low
   always_ff @(negedge clk_core or negedge rst_n) begin
      if (!rst_n)        gate_en <= 1'b0;
      else if (!src_clk) gate_en <= want;
   end

   assign clk_out = src_clk & gate_en;

endmodule

// File: rtl/clk_pwrdn_seq.sv
module clk_pwrdn_seq
   import pdseq_pkg::*;
#(
   parameter int                  NUM_CH      = 4,
   parameter logic [2*NUM_CH-1:0] CH_CLASS    = 8'b00_10_10_01,
   parameter int                  XTAL_SETTLE = 200000,
   parameter int                  PLL_SETTLE  = 133000,
   parameter int                  CORE_KHZ    = 133333
) (
   input  logic              clk_core,
   input  logic              rst_n,
   input  logic              pwrdn_n,
   input  logic              cpu_stop_n,
   input  logic              pci_stop_n,
   input  logic [NUM_CH-1:0] src_clk,
   output logic [NUM_CH-1:0] gate_en,
   output logic [NUM_CH-1:0] clk_out,
   output logic              xtal_en,
   output logic              vco_en
);

   localparam int SYNC_DEPTH    = 2;
   localparam int BUDGET_CYCLES = CORE_KHZ * 3;
   localparam int UP_CYCLES     = XTAL_SETTLE + PLL_SETTLE + SYNC_DEPTH + 2;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (XTAL_SETTLE < 1 || PLL_SETTLE < 1) begin : g_bad_settle
      $error("settle counts must be at least 1");
   end
   if (UP_CYCLES >= BUDGET_CYCLES) begin : g_bad_budget
      $error("restart latency exceeds the 3 ms budget");
   end

   logic [2:0] pins_sync;
   logic       pd_req, cpu_stop, pci_stop;
   logic       run_ok;

   pdseq_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
      .clk_core (clk_core),
      .rst_n    (rst_n),
      .d        ({pci_stop_n, cpu_stop_n, pwrdn_n}),
      .q        (pins_sync)
   );

   assign pd_req   = ~pins_sync[0];
   assign cpu_stop = ~pins_sync[1];
   assign pci_stop = ~pins_sync[2];

   pdseq_fsm #(.XTAL_SETTLE(XTAL_SETTLE), .PLL_SETTLE(PLL_SETTLE)) u_fsm (
      .clk_core (clk_core),
      .rst_n    (rst_n),
      .pd_req   (pd_req),
      .all_off  (gate_en == '0),
      .run_ok   (run_ok),
      .xtal_en  (xtal_en),
      .vco_en   (vco_en)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [1:0] CLS = CH_CLASS[2*i +: 2];
      logic want;

      if (CLS == CLS_CPU) begin : g_cpu
         assign want = run_ok & ~cpu_stop;
      end else if (CLS == CLS_PCI) begin : g_pci
         assign want = run_ok & ~pci_stop;
      end else if (CLS == CLS_FREE) begin : g_free
         assign want = run_ok;
      end else begin : g_bad_cls
         $error("unknown channel class");
         assign want = 1'b0;
      end

      pdseq_gate_cell u_gate (
         .clk_core (clk_core),
         .rst_n    (rst_n),
         .src_clk  (src_clk[i]),
         .want     (want),
         .gate_en  (gate_en[i]),
         .clk_out  (clk_out[i])
      );
   end

endmodule

// File: rtl/clk_pwrdn_seq_chk.sv
module clk_pwrdn_seq_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk_core,
   input logic              rst_n,
   input logic [NUM_CH-1:0] src_clk,
   input logic [NUM_CH-1:0] gate_en,
   input logic              xtal_en,
   input logic              vco_en
);

   // R4
   no_runt_chk: assert property (@(negedge clk_core) disable iff (!rst_n)
      ((gate_en ^ $past(gate_en)) & $past(src_clk)) == '0);

   // R3
   vco_off_after_gates_chk: assert property (@(negedge clk_core) disable iff (!rst_n)
      $fell(vco_en) |-> (gate_en == '0));

   // R3
   xtal_off_after_gates_chk: assert property (@(negedge clk_core) disable iff (!rst_n)
      $fell(xtal_en) |-> (gate_en == '0));

   // R5
   xtal_before_vco_chk: assert property (@(negedge clk_core) disable iff (!rst_n)
      vco_en |-> xtal_en);

   // R6
   gate_needs_osc_chk: assert property (@(negedge clk_core) disable iff (!rst_n)
      (gate_en != '0) |-> vco_en);

endmodule

bind clk_pwrdn_seq clk_pwrdn_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk_core (clk_core),
   .rst_n    (rst_n),
   .src_clk  (src_clk),
   .gate_en  (gate_en),
   .xtal_en  (xtal_en),
   .vco_en   (vco_en)
);

// File: tb/tb_clk_pwrdn_seq.sv
`timescale 1ns/1ps
module tb_clk_pwrdn_seq;

   localparam int N  = 4;
   localparam int XS = 4;
   localparam int PS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwrdn_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
   logic [N-1:0] src = '0;
   logic [N-1:0] gate_en, clk_out;
   logic xtal_en, vco_en;

   int checks = 0, errors = 0, cyc = 0;
   int half[N] = '{1, 2, 3, 5};
   int cls[N]  = '{1, 2, 2, 0};
   int scnt[N] = '{0, 0, 0, 0};

   clk_pwrdn_seq #(.NUM_CH(N), .CH_CLASS(8'b00_10_10_01), .XTAL_SETTLE(XS),
                   .PLL_SETTLE(PS), .CORE_KHZ(1000)) dut (
      .clk_core(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .cpu_stop_n(cpu_stop_n),
      .pci_stop_n(pci_stop_n), .src_clk(src), .gate_en(gate_en), .clk_out(clk_out),
      .xtal_en(xtal_en), .vco_en(vco_en));

   always #10 clk = ~clk;

   // source clocks move just after the rising edge
   always @(posedge clk) begin
      #1;
      for (int i = 0; i < N; i++) begin
         scnt[i] = scnt[i] + 1;
         if (scnt[i] >= half[i]) begin
            scnt[i] = 0;
            src[i] = ~src[i];
         end
      end
   end

   // behavioural reference: 0 run, 1 stop outputs, 2 osc off, 3 osc start, 4 settle
   int m_state = 0, m_cnt = 0;
   bit [1:0] m_pd = 2'b11, m_cs = 2'b11, m_ps = 2'b11;
   bit [N-1:0] m_gate = '0;

   always @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_gate = '0;
         m_pd = 2'b11; m_cs = 2'b11; m_ps = 2'b11;
      end else begin
         bit pdr, cst, pst, runok;
         bit [N-1:0] ng;
         int ns;
         pdr = !m_pd[1]; cst = !m_cs[1]; pst = !m_ps[1];
         runok = (m_state == 0) && !pdr;
         for (int i = 0; i < N; i++) begin
            bit w;
            w = runok && !(cls[i] == 1 && cst) && !(cls[i] == 2 && pst);
            ng[i] = src[i] ? m_gate[i] : w;
         end
         ns = m_state;
         if (m_state == 0) begin
            if (pdr) ns = 1;
         end else if (m_state == 1) begin
            if (m_gate == '0) ns = 2;
         end else if (m_state == 2) begin
            if (!pdr) begin ns = 3; m_cnt = XS; end
         end else if (m_state == 3) begin
            m_cnt = m_cnt - 1;
            if (pdr) ns = 2;
            else if (m_cnt == 0) begin ns = 4; m_cnt = PS; end
         end else begin
            m_cnt = m_cnt - 1;
            if (pdr) ns = 2;
            else if (m_cnt == 0) ns = 0;
         end
         m_state = ns;
         m_gate = ng;
         m_pd = {m_pd[0], pwrdn_n};
         m_cs = {m_cs[0], cpu_stop_n};
         m_ps = {m_ps[0], pci_stop_n};
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare with the model every cycle, away from the falling edge
   always @(posedge clk) begin
      #2;
      chk(gate_en == m_gate, "R2 gate_en vs model", int'(gate_en), int'(m_gate));
      chk({xtal_en, vco_en} == {m_state != 2, m_state != 2 && m_state != 3},
          "R5 osc enables vs model", int'({xtal_en, vco_en}),
          int'({m_state != 2, m_state != 2 && m_state != 3}));
      chk(clk_out == (src & gate_en), "R11 clk_out", int'(clk_out), int'(src & gate_en));
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic samp(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic drive_at_edge();
      @(posedge clk);
      #1;
   endtask

   initial begin
      int kx, kv, kg, k;
      samp(3);
      // R10
      chk(gate_en == '0 && clk_out == '0, "R10 reset gates", int'(gate_en), 0);
      chk(xtal_en && vco_en, "R10 reset osc", int'({xtal_en, vco_en}), 3);
      drive_at_edge(); rst_n = 1'b1;
      samp(15);
      chk(gate_en == 4'hF, "R8 all running", int'(gate_en), 4'hF);
      // R8 class stops
      drive_at_edge(); cpu_stop_n = 1'b0;
      samp(15);
      chk(gate_en == 4'b1110, "R8 cpu stop", int'(gate_en), 4'b1110);
      drive_at_edge(); pci_stop_n = 1'b0;
      samp(15);
      chk(gate_en == 4'b1000, "R8 pci stop", int'(gate_en), 4'b1000);
      chk(clk_out == (src & 4'b1000), "R11 free channel passes", int'(clk_out), int'(src & 4'b1000));
      drive_at_edge(); cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      samp(15);
      chk(gate_en == 4'hF, "R8 stops released", int'(gate_en), 4'hF);
      // R1 and R2: power-down entry
      drive_at_edge(); pwrdn_n = 1'b0;
      samp(2);
      chk(gate_en == 4'hF, "R1 not yet visible at edge 2", int'(gate_en), 4'hF);
      samp(11);
      chk(gate_en == '0, "R2 all parked", int'(gate_en), 0);
      k = 0;
      while (vco_en && k < 40) begin samp(1); k++; end
      // R3
      chk(!vco_en && !xtal_en && gate_en == '0, "R3 osc off after gates", int'({xtal_en, vco_en, gate_en}), 0);
      // R7
      drive_at_edge(); cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
      samp(4);
      drive_at_edge(); cpu_stop_n = 1'b1;
      samp(4);
      chk(gate_en == '0 && !xtal_en && !vco_en, "R7 stops ignored", int'({xtal_en, vco_en, gate_en}), 0);
      drive_at_edge(); pci_stop_n = 1'b1;
      samp(4);
      chk(gate_en == '0 && !xtal_en && !vco_en, "R7 stops ignored after release", int'({xtal_en, vco_en, gate_en}), 0);
      // R5 and R6: restart order and timing
      drive_at_edge(); pwrdn_n = 1'b1;
      kx = 0; kv = 0; kg = 0;
      for (int j = 1; j <= 40; j++) begin
         samp(1);
         if (xtal_en && kx == 0) kx = j;
         if (vco_en && kv == 0) kv = j;
         if (gate_en != '0 && kg == 0) kg = j;
      end
      chk(kx == 3, "R5 xtal restart edge", kx, 3);
      chk(kv == 3 + XS, "R5 vco restart edge", kv, 3 + XS);
      chk(kg >= 4 + XS + PS && kg <= 14 + XS + PS, "R6 gates reopen window", kg, 4 + XS + PS);
      chk(gate_en == 4'hF, "R2 all running again", int'(gate_en), 4'hF);
      // R9: abort during PLL lock
      drive_at_edge(); pwrdn_n = 1'b0;
      k = 0;
      while (xtal_en && k < 40) begin samp(1); k++; end
      drive_at_edge(); pwrdn_n = 1'b1;
      k = 0;
      while (!vco_en && k < 40) begin samp(1); k++; end
      drive_at_edge(); pwrdn_n = 1'b0;
      samp(2);
      chk(vco_en && xtal_en, "R9 still locking at edge 2", int'({xtal_en, vco_en}), 3);
      samp(1);
      chk(!vco_en && !xtal_en && gate_en == '0, "R9 abort to osc off", int'({xtal_en, vco_en, gate_en}), 0);
      drive_at_edge(); pwrdn_n = 1'b1;
      samp(40);
      chk(gate_en == 4'hF && xtal_en && vco_en, "R9 recovers", int'({xtal_en, vco_en, gate_en}), 8'h3F);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule